// File: doc/BRIEF.md
# Synchronous Serial Master Receiver

This block is the receive side of a clocked serial link on which it is the clock master. It drives a shift clock from a programmable divisor and samples one data line once per bit. It assembles 8-bit or 9-bit words, least significant bit first, and places each finished word in a holding register. The holding register carries a completion flag, an interrupt line gated by an enable, and an overrun flag.

Software starts reception in one of two ways. A one-shot request fetches exactly one word and is then withdrawn by the hardware. A continuous enable keeps fetching words back to back until software drops it. When both are active, the continuous enable governs. Dropping the continuous enable also clears a latched overrun. The clock polarity input sets the level at which the clock idles. The data line is always sampled on the clock edge that returns the clock to that idle level.

Top module: `srx_master`

## Requirements
- R1: After reset, `sclk` equals `cfg_pol`, and `rx_done`, `rx_ovr`, `rx_bit9`, `single_pending` and `rx_data` are all 0.
- R2: Each half period of `sclk` lasts N+1 clock cycles. N is `div_lo` when `cfg_div16`=0 and {`div_hi`,`div_lo`} when `cfg_div16`=1. The first clock transition of a word comes N+1 cycles after reception starts.
- R3: Outside a word, `sclk` holds the level `cfg_pol`. Within a word, `sdat` is sampled on each transition of `sclk` back to that level (falling when `cfg_pol`=0, rising when `cfg_pol`=1).
- R4: Bits arrive least significant first. The first sample is bit 0 of `rx_data`. With `cfg_nine`=1 the ninth sample appears on `rx_bit9`. With `cfg_nine`=0 a word is 8 samples and `rx_bit9` is 0.
- R5: A pulse on `single_go` sets `single_pending`. Exactly one word is then received, `single_pending` returns to 0 when that word completes, and `sclk` stays idle afterwards.
- R6: While `cont_en`=1, words are received back to back with no idle gap. If `cont_en` and `single_pending` are both 0 during a word, the partial word is dropped, the clock returns to idle, and the holding register is unchanged.
- R7: If `cont_en` and `single_pending` are both 1, reception continues past the first word.
- R8: `rx_done` rises in the cycle after a word completes. A cycle with `rd_ack`=1 clears it. `rx_irq` equals `rx_done` AND `irq_en`.
- R9: If a word completes while `rx_done`=1 and `rd_ack`=0, `rx_ovr` is set and the new word is discarded (`rx_data` and `rx_bit9` keep their values). Reception stops, and no new word starts while `rx_ovr`=1.
- R10: `rx_ovr` is cleared in the cycle after `cont_en` goes from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_pol | input | 1 | Idle level of the shift clock |
| cfg_nine | input | 1 | 1 selects 9-bit words |
| cfg_div16 | input | 1 | 1 selects the 16-bit divisor |
| div_hi | input | 8 | Divisor high byte |
| div_lo | input | 8 | Divisor low byte |
| cont_en | input | 1 | Continuous receive enable |
| single_go | input | 1 | One-cycle request for a single word |
| rd_ack | input | 1 | Holding register read strobe |
| irq_en | input | 1 | Receive interrupt enable |
| sdat | input | 1 | Serial data line |
| sclk | output | 1 | Generated shift clock |
| rx_data | output | 8 | Received byte |
| rx_bit9 | output | 1 | Ninth received bit |
| rx_done | output | 1 | Word-complete flag |
| rx_irq | output | 1 | Receive interrupt |
| rx_ovr | output | 1 | Overrun flag |
| single_pending | output | 1 | Single-word request outstanding |

## Verification
The hardest state to reach is an overrun. It needs a second word to finish while the first still sits unread. The bench must then see that the engine stays halted, even with the continuous enable still high, until that enable falls. The stimulus gets there by turning off the bench's automatic reader, running continuous reception at the fastest divisor, and waiting two word times. It then holds the enable high for a while longer before dropping it. A behavioural model that counts half periods and sampled bits checks every output on every clock throughout.

// File: rtl/srx_pkg.sv
package srx_pkg;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned WORD_MAX  = BYTE_W + 1;
    localparam int unsigned BIT_IDX_W = $clog2(WORD_MAX + 1);

    typedef struct packed {
        logic                 run;
        logic                 ph;
        logic [BIT_IDX_W-1:0] nbits;
        logic [WORD_MAX-1:0]  shreg;
        logic                 single;
    } core_st_t;

    typedef struct packed {
        logic              done;
        logic              ovr;
        logic              cont_prev;
        logic [BYTE_W-1:0] data;
        logic              bit9;
    } hold_st_t;
endpackage

// File: rtl/srx_baud.sv
module srx_baud #(
    parameter int unsigned HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wide,
    input  logic [HALF_W-1:0] hi,
    input  logic [HALF_W-1:0] lo,
    output logic              tick
);
    localparam int unsigned CNT_W = 2 * HALF_W;

    logic [CNT_W-1:0] cnt_d, cnt_q, limit;

    always_comb begin
        limit = wide ? {hi, lo} : {{HALF_W{1'b0}}, lo};
        tick  = run && (cnt_q >= limit);
        cnt_d = (run && !tick) ? cnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2: a run always begins counting from zero
    a_r2_fresh_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !$past(run)) |-> (cnt_q == '0));
endmodule

// File: rtl/srx_core.sv
module srx_core
    import srx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                cont_en,
    input  logic                single_go,
    input  logic                nine,
    input  logic                sdat,
    input  logic                hold_ovr,
    input  logic                hold_full,
    output logic                run,
    output logic                ph,
    output logic                word_ok,
    output logic [WORD_MAX-1:0] word,
    output logic                single_pending
);
    core_st_t st_d, st_q;
    logic [BIT_IDX_W-1:0] last_idx;
    logic [WORD_MAX-1:0]  word_full;

    always_comb begin
        st_d      = st_q;
        word_ok   = 1'b0;
        last_idx  = nine ? BIT_IDX_W'(WORD_MAX - 1) : BIT_IDX_W'(WORD_MAX - 2);
        word_full = st_q.shreg;
        if (tick && st_q.ph) word_full[st_q.nbits] = sdat;

        if (!st_q.run) begin
            if ((cont_en || st_q.single) && !hold_ovr) begin
                st_d.run   = 1'b1;
                st_d.ph    = 1'b0;
                st_d.nbits = '0;
                st_d.shreg = '0;
            end
        end else if (!cont_en && !st_q.single) begin
            st_d.run = 1'b0;
            st_d.ph  = 1'b0;
        end else if (tick) begin
            st_d.ph = !st_q.ph;
            if (st_q.ph) begin
                st_d.shreg = word_full;
                st_d.nbits = st_q.nbits + 1'b1;
                if (st_q.nbits == last_idx) begin
                    word_ok     = 1'b1;
                    st_d.single = 1'b0;
                    st_d.nbits  = '0;
                    st_d.shreg  = '0;
                    if (!(cont_en && !hold_full)) st_d.run = 1'b0;
                end
            end
        end

        if (single_go) st_d.single = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run            = st_q.run;
    assign ph             = st_q.ph;
    assign word           = word_full;
    assign single_pending = st_q.single;

    a_r5_single_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ok && !single_go) |=> !single_pending);
    a_r9_halt_on_full: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ok && hold_full) |=> !run);
    a_r6_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cont_en && !single_pending && !single_go) |=> (!run && !ph));
    a_r3_idle_phase: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !ph);
endmodule

// File: rtl/srx_hold.sv
module srx_hold
    import srx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                word_ok,
    input  logic [WORD_MAX-1:0] word,
    input  logic                nine,
    input  logic                rd_ack,
    input  logic                cont_en,
    output logic                done,
    output logic                ovr,
    output logic                full,
    output logic [BYTE_W-1:0]   data,
    output logic                bit9
);
    hold_st_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        full           = st_q.done && !rd_ack;
        st_d.cont_prev = cont_en;
        if (rd_ack) st_d.done = 1'b0;
        if (st_q.cont_prev && !cont_en) st_d.ovr = 1'b0;
        if (word_ok) begin
            if (full) begin
                st_d.ovr = 1'b1;
            end else begin
                st_d.done = 1'b1;
                st_d.data = word[BYTE_W-1:0];
                st_d.bit9 = nine && word[WORD_MAX-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done = st_q.done;
    assign ovr  = st_q.ovr;
    assign data = st_q.data;
    assign bit9 = st_q.bit9;

    a_r8_done_source: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(done)) |-> $past(word_ok));
    a_r9_ovr_needs_unread: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !$past(ovr)) |-> $past(done));
    a_r9_data_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !$past(ovr)) |-> $stable(data));
    a_r10_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cont_en) && !cont_en && !word_ok) |=> !ovr);
endmodule

// File: rtl/srx_master.sv
module srx_master
    import srx_pkg::*;
#(
    parameter int unsigned HALF_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_pol,
    input  logic              cfg_nine,
    input  logic              cfg_div16,
    input  logic [HALF_W-1:0] div_hi,
    input  logic [HALF_W-1:0] div_lo,
    input  logic              cont_en,
    input  logic              single_go,
    input  logic              rd_ack,
    input  logic              irq_en,
    input  logic              sdat,
    output logic              sclk,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              rx_done,
    output logic              rx_irq,
    output logic              rx_ovr,
    output logic              single_pending
);
    logic                tick, run, ph, word_ok, full;
    logic [WORD_MAX-1:0] word;

    srx_baud #(.HALF_W(HALF_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(run), .wide(cfg_div16),
        .hi(div_hi), .lo(div_lo), .tick(tick)
    );

    srx_core u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cont_en(cont_en),
        .single_go(single_go), .nine(cfg_nine), .sdat(sdat),
        .hold_ovr(rx_ovr), .hold_full(full), .run(run), .ph(ph),
        .word_ok(word_ok), .word(word), .single_pending(single_pending)
    );

    srx_hold u_hold (
        .clk(clk), .rst_n(rst_n), .word_ok(word_ok), .word(word),
        .nine(cfg_nine), .rd_ack(rd_ack), .cont_en(cont_en),
        .done(rx_done), .ovr(rx_ovr), .full(full), .data(rx_data), .bit9(rx_bit9)
    );

    assign sclk   = ph ^ cfg_pol;
    assign rx_irq = rx_done && irq_en;

    a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (sclk == cfg_pol));
    a_r9_no_start_in_ovr: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && rx_ovr) |=> !run);
endmodule

// File: tb/sim_srx_master.sv
module sim_srx_master;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_pol = 1'b0, cfg_nine = 1'b0, cfg_div16 = 1'b0;
    logic [7:0] div_hi = 8'd0, div_lo = 8'd0;
    logic       cont_en = 1'b0, single_go = 1'b0, rd_ack = 1'b0, irq_en = 1'b0, sdat = 1'b0;
    logic       sclk, rx_bit9, rx_done, rx_irq, rx_ovr, single_pending;
    logic [7:0] rx_data;

    logic        auto_rd = 1'b0, man_rd = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    int vectors = 0, errors = 0, rd_cnt = 0, cycles = 0;

    // reference model state
    int m_run, m_cyc, m_half, m_acc, m_single, m_done, m_data, m_b9, m_ovr, m_contp;
    int lim, nbit, idx;
    bit full, comp;

    always #4 clk = ~clk;

    srx_master u0 (
        .clk(clk), .rst_n(rst_n), .cfg_pol(cfg_pol), .cfg_nine(cfg_nine),
        .cfg_div16(cfg_div16), .div_hi(div_hi), .div_lo(div_lo),
        .cont_en(cont_en), .single_go(single_go), .rd_ack(rd_ack),
        .irq_en(irq_en), .sdat(sdat), .sclk(sclk), .rx_data(rx_data),
        .rx_bit9(rx_bit9), .rx_done(rx_done), .rx_irq(rx_irq),
        .rx_ovr(rx_ovr), .single_pending(single_pending)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_cyc = 0; m_half = 0; m_acc = 0; m_single = 0;
            m_done = 0; m_data = 0; m_b9 = 0; m_ovr = 0; m_contp = 0;
        end else begin
            lim  = cfg_div16 ? (int'(div_hi) * 256 + int'(div_lo)) : int'(div_lo);
            nbit = cfg_nine ? 9 : 8;
            full = (m_done != 0) && !rd_ack;
            comp = 0;
            if (m_run == 0) begin
                if ((cont_en || m_single != 0) && m_ovr == 0) begin
                    m_run = 1; m_cyc = 0; m_half = 0; m_acc = 0;
                end
            end else if (!cont_en && m_single == 0) begin
                m_run = 0; m_half = 0;
            end else if (m_cyc >= lim) begin
                m_cyc = 0;
                m_half++;
                if (m_half % 2 == 0) begin
                    idx = m_half / 2 - 1;
                    if (sdat) m_acc = m_acc | (1 << idx);
                    if (idx == nbit - 1) comp = 1;
                end
            end else begin
                m_cyc++;
            end
            if (m_contp != 0 && !cont_en) m_ovr = 0;
            if (rd_ack) m_done = 0;
            if (comp) begin
                if (full) m_ovr = 1;
                else begin
                    m_done = 1;
                    m_data = m_acc & 255;
                    m_b9   = cfg_nine ? ((m_acc >> 8) & 1) : 0;
                end
                m_single = 0;
                if (cont_en && !full) begin
                    m_cyc = 0; m_half = 0; m_acc = 0;
                end else begin
                    m_run = 0; m_half = 0;
                end
            end
            if (single_go) m_single = 1;
            m_contp = cont_en ? 1 : 0;
        end
    end

    // compare every cycle, well after the edge and after input changes
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            chk("R3 sclk", sclk, ((m_run != 0 && (m_half % 2) == 1) ? 1 : 0) ^ cfg_pol);
            chk("R4 rx_data", rx_data, m_data);
            chk("R4 rx_bit9", rx_bit9, m_b9);
            chk("R8 rx_done", rx_done, m_done);
            chk("R8 rx_irq", rx_irq, m_done & irq_en);
            chk("R9 rx_ovr", rx_ovr, m_ovr);
            chk("R5 single_pending", single_pending, m_single);
        end
    end

    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        sdat <= lfsr[0];
        if (auto_rd) rd_ack <= rx_done && !rd_ack;
        else         rd_ack <= man_rd;
        if ((auto_rd && rx_done && !rd_ack) || (!auto_rd && man_rd)) rd_cnt <= rd_cnt + 1;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_single;
        @(negedge clk); single_go = 1'b1;
        @(negedge clk); single_go = 1'b0;
    endtask

    task automatic manual_read;
        @(negedge clk); man_rd = 1'b1;
        wait_cyc(2);    man_rd = 1'b0;
        wait_cyc(2);
    endtask

    task automatic wait_single_done;
        int guard = 0;
        while (single_pending && guard < 20000) begin @(negedge clk); guard++; end
        wait_cyc(3);
    endtask

    int  half_len, base;
    logic s0;

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        #1;
        chk("R1 sclk idle", sclk, 0);
        chk("R1 rx_done", rx_done, 0);
        chk("R1 rx_ovr", rx_ovr, 0);
        chk("R1 rx_data", rx_data, 0);
        chk("R1 single_pending", single_pending, 0);

        // R5 single word, polarity 0, 8 bit, irq enabled
        div_lo = 8'd1; irq_en = 1'b1;
        pulse_single();
        chk("R5 pending set", single_pending, 1);
        wait_single_done();
        chk("R5 word landed", rx_done, 1);
        chk("R8 irq raised", rx_irq, 1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); #1;
            chk("R5 clock stays idle", sclk, 0);
        end
        irq_en = 1'b0;
        @(negedge clk); #1;
        chk("R8 irq masked", rx_irq, 0);
        manual_read();
        chk("R8 read clears", rx_done, 0);

        // R3 R4 polarity 1, 9-bit words
        cfg_pol = 1'b1; cfg_nine = 1'b1; div_lo = 8'd2; auto_rd = 1'b1;
        wait_cyc(2); #1;
        chk("R3 idle high", sclk, 1);
        for (int k = 0; k < 3; k++) begin
            pulse_single();
            wait_single_done();
        end
        auto_rd = 1'b0; cfg_nine = 1'b0; cfg_pol = 1'b0;
        wait_cyc(4);

        // R2 sixteen-bit divisor: half period 257 cycles
        cfg_div16 = 1'b1; div_hi = 8'd1; div_lo = 8'd0;
        pulse_single();
        #1; s0 = sclk;
        while (sclk == s0) begin @(negedge clk); #1; end
        half_len = 0; s0 = sclk;
        while (sclk == s0 && half_len < 1000) begin @(negedge clk); #1; half_len++; end
        chk("R2 half period", half_len, 257);
        wait_single_done();
        manual_read();
        cfg_div16 = 1'b0; div_hi = 8'd0; div_lo = 8'd0;

        // R6 continuous with reader, fastest divisor
        auto_rd = 1'b1; base = rd_cnt;
        @(negedge clk); cont_en = 1'b1;
        wait_cyc(200);
        chk("R6 several words", (rd_cnt - base) >= 5 ? 1 : 0, 1);
        @(negedge clk); cont_en = 1'b0;
        wait_cyc(2); #1;
        chk("R6 stop idles", sclk, 0);
        wait_cyc(4);

        // R7 both enables
        base = rd_cnt;
        @(negedge clk); cont_en = 1'b1; single_go = 1'b1;
        @(negedge clk); single_go = 1'b0;
        wait_cyc(120);
        chk("R7 continues", (rd_cnt - base) >= 3 ? 1 : 0, 1);
        @(negedge clk); cont_en = 1'b0;
        wait_cyc(6);
        auto_rd = 1'b0;
        wait_cyc(4);

        // R9 overrun then R10 clear
        @(negedge clk); cont_en = 1'b1;
        wait_cyc(120); #1;
        chk("R9 overrun set", rx_ovr, 1);
        chk("R9 halted", sclk, 0);
        wait_cyc(40); #1;
        chk("R9 stays halted", sclk, 0);
        @(negedge clk); cont_en = 1'b0;
        wait_cyc(2); #1;
        chk("R10 overrun cleared", rx_ovr, 0);
        manual_read();

        // R6 abort mid-word leaves holding register alone
        base = m_data;
        @(negedge clk); cont_en = 1'b1;
        wait_cyc(7);
        @(negedge clk); cont_en = 1'b0;
        wait_cyc(2); #1;
        chk("R6 abort idle", sclk, 0);
        chk("R6 abort no word", rx_done, 0);
        wait_cyc(10);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule